// File: doc/BRIEF.md
# Priority Interrupt Arbiter with Mask

The block gathers level-sensitive interrupt requests from a set of peripheral sources and forwards at most one of them to the CPU. Each source reads its 4-bit priority from a field of a bank of seven 16-bit priority registers. These registers are written and read over a simple address, write-enable and data bus. Some pairs of sources share one field. The rest each own a field.

On every peripheral clock edge the block samples the requests and the CPU's 4-bit mask level. It then picks the pending source with the highest programmed level. A fixed order settles ties. The CPU request is raised only when the winning level is strictly above the sampled mask. Requests that lose stay visible and win once the sources ahead of them drop. When the CPU acknowledges, an event code that names the winning source is latched for the handler.

Top module: `prio_irq_arbiter`

## Requirements
- R1: After reset, irq_o, irq_lvl_o and evt_code_o are 0, and every priority register reads 0.
- R2: A bus write to address 0..6 updates that register, and the data is read back on bus_rdata_o. A write to address 7 changes nothing, and that address reads 0. Register r bits [4j+3:4j] hold field 4r+j.
- R3: Among pending sources with a nonzero level, the highest level wins.
- R4: On a level tie between different fields, the source on the lower field index wins.
- R5: Sources 2k and 2k+1 (k<4) share field k. When both are pending at equal level, the odd source 2k+1 wins. Sources 8..15 use fields 4..11.
- R6: A source whose field is 0 never raises irq_o.
- R7: irq_o is 1 only when the winning level is strictly greater than the sampled mask. While irq_o is 0, irq_lvl_o reads 0. Otherwise irq_lvl_o gives the winning level.
- R8: req_i and mask_i are sampled on one clock edge, and the result is visible on irq_o after the next edge.
- R9: When ack_i is 1 at an edge while irq_o is 1, evt_code_o becomes 0x200 + 0x20 × winning source index. At any other time evt_code_o holds its value.
- R10: A pending request that loses is not dropped. It is forwarded once the higher-priority request goes away.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 16 | Level interrupt requests, one per source |
| mask_i | input | 4 | CPU interrupt mask level |
| ack_i | input | 1 | Single-cycle acknowledge from the CPU |
| bus_addr_i | input | 3 | Priority register address |
| bus_we_i | input | 1 | Register write enable |
| bus_wdata_i | input | 16 | Register write data |
| bus_rdata_o | output | 16 | Register read data for bus_addr_i |
| irq_o | output | 1 | Interrupt request to the CPU |
| irq_lvl_o | output | 4 | Level of the forwarded request |
| evt_code_o | output | 12 | Event code of the acknowledged source |

## Verification
The assertions assume that req_i and mask_i are driven from reset onward. They also assume that ack_i is a single-cycle pulse. Under those conditions, irq_o can be related to the requests and mask seen two edges earlier.

The bench changes requests and mask only away from the clock edge and holds them for at least two edges before sampling. It gives acknowledges as one-cycle pulses. Priority registers are rewritten only while the outcome is not being measured.

// File: rtl/pia_pkg.sv
package pia_pkg;
  localparam int LVL_W   = 4;
  localparam int FLD_PER = 4;
  localparam int REG_W   = LVL_W * FLD_PER;

  // Order of evaluation: shared pairs put the odd source first.
  function automatic int ord_src(input int k, input int n_shared);
    return (k < n_shared) ? (k ^ 1) : k;
  endfunction

  function automatic int fld_of(input int s, input int n_shared);
    return (s < n_shared) ? (s >> 1) : (s - n_shared / 2);
  endfunction
endpackage

// File: rtl/pia_regbank.sv
module pia_regbank
  import pia_pkg::*;
#(
  parameter int N_REG  = 7,
  parameter int ADDR_W = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic                     we_i,
  input  logic [REG_W-1:0]         wdata_i,
  output logic [REG_W-1:0]         rdata_o,
  output logic [N_REG*REG_W-1:0]   fields_o
);
  logic [REG_W-1:0] regs_q [N_REG];
  logic             addr_ok;

  assign addr_ok = (32'(addr_i) < N_REG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < N_REG; r++) regs_q[r] <= '0;
    end else if (we_i && addr_ok) begin
      regs_q[addr_i] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int r = 0; r < N_REG; r++)
      if (32'(addr_i) == r) rdata_o = regs_q[r];
  end

  for (genvar r = 0; r < N_REG; r++) begin : g_flat
    assign fields_o[r*REG_W +: REG_W] = regs_q[r];
  end
endmodule

// File: rtl/pia_arbiter.sv
module pia_arbiter
  import pia_pkg::*;
#(
  parameter int N_SRC    = 16,
  parameter int N_SHARED = 8,
  parameter int N_FLD    = 28,
  parameter int SRC_W    = 4
) (
  input  logic [N_SRC-1:0]       req_i,
  input  logic [N_FLD*LVL_W-1:0] fields_i,
  output logic [SRC_W-1:0]       win_src_o,
  output logic [LVL_W-1:0]       win_lvl_o
);
  // Strict '>' keeps the earlier entry in evaluation order on ties.
  always_comb begin
    win_src_o = '0;
    win_lvl_o = '0;
    for (int k = 0; k < N_SRC; k++) begin
      int s;
      int f;
      logic [LVL_W-1:0] lvl;
      s   = ord_src(k, N_SHARED);
      f   = fld_of(s, N_SHARED);
      lvl = fields_i[f*LVL_W +: LVL_W];
      if (req_i[s] && (lvl > win_lvl_o)) begin
        win_lvl_o = lvl;
        win_src_o = SRC_W'(s);
      end
    end
  end
endmodule

// File: rtl/pia_evt.sv
module pia_evt #(
  parameter int          SRC_W    = 4,
  parameter int          EVT_W    = 12,
  parameter logic [11:0] EVT_BASE = 12'h200,
  parameter logic [11:0] EVT_STEP = 12'h020
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic [SRC_W-1:0] src_i,
  output logic [EVT_W-1:0] evt_o
);
  logic [EVT_W-1:0] code;
  assign code = EVT_W'(EVT_BASE) + EVT_W'(EVT_STEP) * EVT_W'(src_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     evt_o <= '0;
    else if (take_i) evt_o <= code;
  end
endmodule

// File: rtl/prio_irq_arbiter.sv
module prio_irq_arbiter
  import pia_pkg::*;
#(
  parameter int N_SRC    = 16,
  parameter int N_SHARED = 8,
  parameter int N_REG    = 7,
  parameter int EVT_W    = 12,
  parameter int ADDR_W   = $clog2(N_REG + 1),
  parameter int SRC_W    = $clog2(N_SRC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_SRC-1:0]   req_i,
  input  logic [LVL_W-1:0]   mask_i,
  input  logic               ack_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic               bus_we_i,
  input  logic [REG_W-1:0]   bus_wdata_i,
  output logic [REG_W-1:0]   bus_rdata_o,
  output logic               irq_o,
  output logic [LVL_W-1:0]   irq_lvl_o,
  output logic [EVT_W-1:0]   evt_code_o
);
  localparam int N_FLD = N_REG * FLD_PER;

  logic [N_SRC-1:0]       req_q;
  logic [LVL_W-1:0]       mask_q;
  logic [N_FLD*LVL_W-1:0] fields;
  logic [SRC_W-1:0]       win_src, src_q;
  logic [LVL_W-1:0]       win_lvl;
  logic                   fwd;

  pia_regbank #(.N_REG(N_REG), .ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni,
    .addr_i(bus_addr_i), .we_i(bus_we_i), .wdata_i(bus_wdata_i),
    .rdata_o(bus_rdata_o), .fields_o(fields)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= '0;
      mask_q <= '0;
    end else begin
      req_q  <= req_i;
      mask_q <= mask_i;
    end
  end

  pia_arbiter #(.N_SRC(N_SRC), .N_SHARED(N_SHARED), .N_FLD(N_FLD), .SRC_W(SRC_W)) u_arb (
    .req_i(req_q), .fields_i(fields), .win_src_o(win_src), .win_lvl_o(win_lvl)
  );

  assign fwd = (win_lvl > mask_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o     <= 1'b0;
      irq_lvl_o <= '0;
      src_q     <= '0;
    end else begin
      irq_o     <= fwd;
      irq_lvl_o <= fwd ? win_lvl : '0;
      src_q     <= win_src;
    end
  end

  pia_evt #(.SRC_W(SRC_W), .EVT_W(EVT_W)) u_evt (
    .clk_i, .rst_ni, .take_i(ack_i && irq_o), .src_i(src_q), .evt_o(evt_code_o)
  );
endmodule

// File: rtl/prio_irq_arbiter_chk.sv
module prio_irq_arbiter_chk #(
  parameter int N_SRC = 16,
  parameter int EVT_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_SRC-1:0] req_i,
  input logic [3:0]       mask_i,
  input logic             ack_i,
  input logic             irq_o,
  input logic [3:0]       irq_lvl_o,
  input logic [EVT_W-1:0] evt_code_o
);
  AST_IRQ_ABOVE_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (irq_lvl_o > $past(mask_i, 2))); // R7
  AST_IDLE_LVL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> (irq_lvl_o == 4'd0)); // R7
  AST_NONZERO_LVL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (irq_lvl_o != 4'd0)); // R6
  AST_NO_REQ_NO_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(req_i, 2) == '0) |-> !irq_o); // R8
  AST_EVT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ack_i && irq_o) |=> $stable(evt_code_o)); // R9
endmodule

bind prio_irq_arbiter prio_irq_arbiter_chk #(.N_SRC(N_SRC), .EVT_W(EVT_W)) u_chk (
  .clk_i, .rst_ni, .req_i, .mask_i, .ack_i, .irq_o, .irq_lvl_o, .evt_code_o
);

// File: tb/prio_irq_arbiter_tb.sv
`timescale 1ns/1ps
module prio_irq_arbiter_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] req_i = '0;
  logic [3:0]  mask_i = '0;
  logic        ack_i = 1'b0;
  logic [2:0]  bus_addr_i = '0;
  logic        bus_we_i = 1'b0;
  logic [15:0] bus_wdata_i = '0;
  logic [15:0] bus_rdata_o;
  logic        irq_o;
  logic [3:0]  irq_lvl_o;
  logic [11:0] evt_code_o;

  int checks = 0;
  int errors = 0;
  logic [11:0] exp_evt = '0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  prio_irq_arbiter u_dut (.*);

  // {req[15:0], mask[3:0], irq, lvl[3:0], src[3:0]}
  localparam int NV = 12;
  localparam logic [28:0] VEC [NV] = '{
    {16'h0001, 4'd0,  1'b1, 4'd5,  4'd0},   // R3 single
    {16'h0003, 4'd0,  1'b1, 4'd5,  4'd1},   // R5 odd wins shared field
    {16'h0005, 4'd0,  1'b1, 4'd5,  4'd0},   // R4 lower field wins
    {16'h0030, 4'd0,  1'b0, 4'd0,  4'd0},   // R6 level 0
    {16'h1041, 4'd0,  1'b1, 4'd15, 4'd12},  // R3 highest
    {16'h0240, 4'd0,  1'b1, 4'd9,  4'd6},   // R4 tie fields 3 vs 5
    {16'h00C0, 4'd0,  1'b1, 4'd9,  4'd7},   // R5
    {16'h0001, 4'd5,  1'b0, 4'd0,  4'd0},   // R7 equal to mask
    {16'h0001, 4'd4,  1'b1, 4'd5,  4'd0},   // R7 one above
    {16'hC000, 4'd0,  1'b1, 4'd7,  4'd14},  // R4
    {16'h0400, 4'd11, 1'b1, 4'd12, 4'd10},  // R7
    {16'h1000, 4'd15, 1'b0, 4'd0,  4'd0}    // R7 top mask
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    bus_addr_i = a; bus_wdata_i = d; bus_we_i = 1'b1;
    edges(1);
    bus_we_i = 1'b0;
  endtask

  task automatic rd(input string req, input logic [2:0] a, input logic [15:0] exp);
    bus_addr_i = a;
    #1;
    chk(req, 32'(bus_rdata_o), 32'(exp));
  endtask

  task automatic pulse_ack();
    ack_i = 1'b1;
    edges(1);
    ack_i = 1'b0;
  endtask

  initial begin
    #20000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    edges(2);
    // R1 reset state
    chk("R1 irq", 32'(irq_o), 0);
    chk("R1 lvl", 32'(irq_lvl_o), 0);
    chk("R1 evt", 32'(evt_code_o), 0);
    rst_ni = 1'b1;
    edges(1);
    for (int r = 0; r < 7; r++) rd("R1 reg", 3'(r), 16'h0);

    // R2 write/readback and ignored address
    wr(3'd3, 16'hABCD);
    rd("R2 readback", 3'd3, 16'hABCD);
    wr(3'd7, 16'h1234);
    rd("R2 addr7", 3'd7, 16'h0);
    rd("R2 addr7 no alias", 3'd3, 16'hABCD);
    wr(3'd3, 16'h0000);
    wr(3'd0, 16'h9055);
    wr(3'd1, 16'h1C93);
    wr(3'd2, 16'h770F);
    rd("R2 reg0", 3'd0, 16'h9055);

    // vector table
    for (int v = 0; v < NV; v++) begin
      req_i  = VEC[v][28:13];
      mask_i = VEC[v][12:9];
      edges(2);
      chk($sformatf("R3-vec%0d irq", v), 32'(irq_o), 32'(VEC[v][8]));
      chk($sformatf("R7-vec%0d lvl", v), 32'(irq_lvl_o), 32'(VEC[v][7:4]));
      if (VEC[v][8]) exp_evt = 12'h200 + 12'h020 * 12'(VEC[v][3:0]);
      pulse_ack();
      chk($sformatf("R9-vec%0d evt", v), 32'(evt_code_o), 32'(exp_evt));
      req_i = '0; mask_i = '0;
      edges(2);
    end

    // R8 latency
    req_i = 16'h1000;
    edges(1);
    chk("R8 not yet", 32'(irq_o), 0);
    edges(1);
    chk("R8 after second edge", 32'(irq_o), 1);
    // R9 ack ignored while irq low
    req_i = '0;
    edges(2);
    pulse_ack();
    chk("R9 hold on idle ack", 32'(evt_code_o), 32'(exp_evt));

    // R10 loser stays pending
    req_i = 16'h1001;
    edges(2);
    chk("R10 winner lvl", 32'(irq_lvl_o), 15);
    req_i = 16'h0001;
    edges(2);
    chk("R10 loser now lvl", 32'(irq_lvl_o), 5);
    pulse_ack();
    chk("R10 loser evt", 32'(evt_code_o), 32'h200);

    // R6 reprogram src0 to 0
    wr(3'd0, 16'h9050);
    edges(1);
    chk("R6 disabled field", 32'(irq_o), 0);
    req_i = '0;

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule